// File: doc/BRIEF.md
# Temperature-Compensated Setpoint Interpolator

This block turns an 8-bit temperature code, taken from an ADC, into a 9-bit bias-voltage setpoint code that follows a piecewise-linear curve. The curve is built from a single base code and three 5-bit offsets. The setpoint at the low breakpoint is the base code less one offset. The setpoint at the first high breakpoint is the base code plus a second offset. The setpoint at the second high breakpoint adds a third offset on top of the first high setpoint. Four 8-bit breakpoint codes place these setpoints, and the base code sits at the reference breakpoint. Each output LSB stands for roughly 6.83 mV of bias.

A one-cycle strobe starts a conversion. At the strobe the block picks the segment that the temperature falls in and forms the product of the segment's setpoint rise and the temperature's distance into the segment. A sequential restoring divider then divides that product by the segment width. The quotient is truncated, which rounds toward the lower breakpoint, and is added to the setpoint at the segment's start. A done pulse marks the cycle in which the new setpoint first appears. The breakpoints are expected to be strictly ascending (low < reference < H1 < H2). Offsets that would push a code outside 0..511 are clamped, so a code never wraps.

Top module: `tc_setpoint_interp`

## Requirements
- R1: While reset is active, and on the first cycle after it, `setpoint` is 0 and `done` is 0.
- R2: The base code is `{base_hi, base_lsb}`, with `base_lsb` as bit 0. The low setpoint is base − `off_low`, clamped at 0. The H1 setpoint is base + `off_h1`, clamped at 511. The H2 setpoint is the H1 setpoint + `off_h2`, clamped at 511.
- R3: A temperature equal to a breakpoint gives exactly that breakpoint's setpoint: low setpoint at `bp_low`, base at `bp_ref`, H1 at `bp_h1`, H2 at `bp_h2`.
- R4: A temperature at or below `bp_low` gives the low setpoint. A temperature at or above `bp_h2` gives the H2 setpoint.
- R5: A temperature strictly inside a segment [Ta, Tb) with setpoints Sa and Sb gives Sa + floor((Sb − Sa)·(T − Ta)/(Tb − Ta)). The segments are low→reference, reference→H1 and H1→H2.
- R6: A strobe accepted in cycle k makes `done` high for exactly one cycle, in cycle k+17. `setpoint` takes its new value in that same cycle and holds it while `done` is low.
- R7: A strobe that arrives while a conversion is in progress is ignored. This includes the cycle just before `done` rises. A strobe that arrives in the cycle where `done` is high is accepted.
- R8: The temperature and all configuration inputs are sampled at the accepting strobe. Changing them during a conversion does not alter that conversion's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Strobe: a new temperature code is present |
| temp_code | input | 8 | Temperature code from the ADC |
| base_hi | input | 8 | Upper 8 bits of the base setpoint |
| base_lsb | input | 1 | Bit 0 of the base setpoint |
| off_low | input | 5 | Downward offset for the low setpoint |
| off_h1 | input | 5 | Upward offset from base for the H1 setpoint |
| off_h2 | input | 5 | Upward offset from H1 for the H2 setpoint |
| bp_low | input | 8 | Low temperature breakpoint |
| bp_ref | input | 8 | Reference temperature breakpoint (base setpoint) |
| bp_h1 | input | 8 | First high temperature breakpoint |
| bp_h2 | input | 8 | Second high temperature breakpoint |
| setpoint | output | 9 | Interpolated setpoint code |
| done | output | 1 | One-cycle pulse: setpoint updated |

## Verification
The completion of a conversion and the arrival of a new strobe can fall in the same cycle. A strobe can also land in the cycle just before completion. The bench counts cycles from an accepted strobe and raises a second strobe exactly one cycle before `done` is due. It holds that strobe, with a different temperature, through the `done` cycle. It then judges through a scoreboard that the first strobe is dropped: no extra done pulse appears and no result carries the dropped temperature. It also judges that the strobe held through the `done` cycle starts a fresh conversion whose result matches the model.

// File: rtl/tcsi_pkg.sv
// Shared definitions for the temperature-compensated setpoint interpolator.
// Assumes: widths below are the default geometry; modules take them as parameters.
package tcsi_pkg;
    localparam int TCSI_TEMP_W = 8;
    localparam int TCSI_CODE_W = 9;
    localparam int TCSI_OFF_W  = 5;

    // Which part of the curve a temperature code falls in.
    typedef enum logic [2:0] {
        SEG_CLAMP_LO = 3'd0,
        SEG_LO_REF   = 3'd1,
        SEG_REF_HI1  = 3'd2,
        SEG_HI1_HI2  = 3'd3,
        SEG_CLAMP_HI = 3'd4
    } seg_e;
endpackage

// File: rtl/tcsi_breakpoints.sv
// Derives the setpoint at the low, H1 and H2 breakpoints from the base code
// and the chained offsets, clamping into 0..2^CODE_W-1 rather than wrapping.
// Assumes: OFF_W < CODE_W. Purely combinational.
module tcsi_breakpoints #(
    parameter int CODE_W = tcsi_pkg::TCSI_CODE_W,
    parameter int OFF_W  = tcsi_pkg::TCSI_OFF_W
) (
    input  logic [CODE_W-1:0] base,
    input  logic [OFF_W-1:0]  off_low,
    input  logic [OFF_W-1:0]  off_h1,
    input  logic [OFF_W-1:0]  off_h2,
    output logic [CODE_W-1:0] sp_low,
    output logic [CODE_W-1:0] sp_h1,
    output logic [CODE_W-1:0] sp_h2
);
    localparam int PAD_W = CODE_W - OFF_W;

    logic [CODE_W-1:0] ext_low, ext_h1, ext_h2;
    logic [CODE_W:0]   sum_h1, sum_h2;

    // Zero-extend the offsets to code width.
    always_comb begin
        ext_low = {{PAD_W{1'b0}}, off_low};
        ext_h1  = {{PAD_W{1'b0}}, off_h1};
        ext_h2  = {{PAD_W{1'b0}}, off_h2};
    end

    // Low setpoint: subtract, floor at zero.
    always_comb begin
        sp_low = (ext_low > base) ? '0 : base - ext_low;
    end

    // H1 and H2 setpoints: add, ceiling at full scale.
    always_comb begin
        sum_h1 = {1'b0, base} + {1'b0, ext_h1};
        sp_h1  = sum_h1[CODE_W] ? '1 : sum_h1[CODE_W-1:0];
        sum_h2 = {1'b0, sp_h1} + {1'b0, ext_h2};
        sp_h2  = sum_h2[CODE_W] ? '1 : sum_h2[CODE_W-1:0];
    end
endmodule

// File: rtl/tcsi_segment.sv
// Selects the curve segment for a temperature code and gives its start
// setpoint, setpoint rise, distance into the segment and segment width.
// Assumes: breakpoints ascending; clamps report a zero distance. The ordered
// comparisons guarantee a non-zero width whenever the distance is non-zero.
module tcsi_segment #(
    parameter int TEMP_W = tcsi_pkg::TCSI_TEMP_W,
    parameter int CODE_W = tcsi_pkg::TCSI_CODE_W
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] bp_low,
    input  logic [TEMP_W-1:0] bp_ref,
    input  logic [TEMP_W-1:0] bp_h1,
    input  logic [TEMP_W-1:0] bp_h2,
    input  logic [CODE_W-1:0] base,
    input  logic [CODE_W-1:0] sp_low,
    input  logic [CODE_W-1:0] sp_h1,
    input  logic [CODE_W-1:0] sp_h2,
    output tcsi_pkg::seg_e    seg,
    output logic [CODE_W-1:0] start,
    output logic [CODE_W-1:0] delta,
    output logic [TEMP_W-1:0] num,
    output logic [TEMP_W-1:0] den
);
    import tcsi_pkg::*;

    // Priority-ordered segment decode.
    always_comb begin
        seg   = SEG_CLAMP_LO;
        start = sp_low;
        delta = '0;
        num   = '0;
        den   = TEMP_W'(1);
        if (temp <= bp_low) begin
            seg   = SEG_CLAMP_LO;
            start = sp_low;
        end else if (temp < bp_ref) begin
            seg   = SEG_LO_REF;
            start = sp_low;
            delta = base - sp_low;
            num   = temp - bp_low;
            den   = bp_ref - bp_low;
        end else if (temp < bp_h1) begin
            seg   = SEG_REF_HI1;
            start = base;
            delta = sp_h1 - base;
            num   = temp - bp_ref;
            den   = bp_h1 - bp_ref;
        end else if (temp < bp_h2) begin
            seg   = SEG_HI1_HI2;
            start = sp_h1;
            delta = sp_h2 - sp_h1;
            num   = temp - bp_h1;
            den   = bp_h2 - bp_h1;
        end else begin
            seg   = SEG_CLAMP_HI;
            start = sp_h2;
        end
    end
endmodule

// File: rtl/tcsi_divider.sv
// Sequential restoring divider: one quotient bit per cycle, NUM_W cycles.
// Assumes: divisor non-zero; load is ignored while busy. Exposes the quotient
// as it will stand after the current step so the caller can latch it on the
// final step without an extra cycle.
module tcsi_divider #(
    parameter int NUM_W = 17,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             last,
    output logic [NUM_W-1:0] quo_next
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W-1:0] rem_next;

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        trial    = {rem_q, quo_q[NUM_W-1]};
        fits     = trial >= {1'b0, div_q};
        rem_next = fits ? DEN_W'(trial - {1'b0, div_q}) : DEN_W'(trial);
        quo_next = {quo_q[NUM_W-2:0], fits};
    end

    // Step sequencing and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load && !busy_q) begin
            quo_q  <= dividend;
            rem_q  <= '0;
            div_q  <= divisor;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            quo_q <= quo_next;
            rem_q <= rem_next;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tc_setpoint_interp.sv
// Top of the temperature-compensated setpoint interpolator. On an accepted
// strobe it captures the segment data for the current temperature and
// configuration, runs the divider, and on the final divider step publishes
// start + quotient with a one-cycle done pulse.
// Assumes: breakpoints strictly ascending; strobes during a conversion dropped.
module tc_setpoint_interp #(
    parameter int TEMP_W = tcsi_pkg::TCSI_TEMP_W,
    parameter int CODE_W = tcsi_pkg::TCSI_CODE_W,
    parameter int OFF_W  = tcsi_pkg::TCSI_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [CODE_W-2:0] base_hi,
    input  logic              base_lsb,
    input  logic [OFF_W-1:0]  off_low,
    input  logic [OFF_W-1:0]  off_h1,
    input  logic [OFF_W-1:0]  off_h2,
    input  logic [TEMP_W-1:0] bp_low,
    input  logic [TEMP_W-1:0] bp_ref,
    input  logic [TEMP_W-1:0] bp_h1,
    input  logic [TEMP_W-1:0] bp_h2,
    output logic [CODE_W-1:0] setpoint,
    output logic              done
);
    import tcsi_pkg::*;

    localparam int PROD_W = CODE_W + TEMP_W;

    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] sp_low, sp_h1, sp_h2;
    seg_e              seg;
    logic [CODE_W-1:0] seg_start, seg_delta;
    logic [TEMP_W-1:0] seg_num, seg_den;
    logic [PROD_W-1:0] product;
    logic              div_busy, div_last;
    logic [PROD_W-1:0] quo_next;
    logic              accept;
    seg_e              seg_q;
    logic [CODE_W-1:0] start_q;
    logic [CODE_W-1:0] setpoint_q;
    logic              done_q;

    assign base = {base_hi, base_lsb};

    tcsi_breakpoints #(.CODE_W(CODE_W), .OFF_W(OFF_W)) u_bp (
        .base    (base),
        .off_low (off_low),
        .off_h1  (off_h1),
        .off_h2  (off_h2),
        .sp_low  (sp_low),
        .sp_h1   (sp_h1),
        .sp_h2   (sp_h2)
    );

    tcsi_segment #(.TEMP_W(TEMP_W), .CODE_W(CODE_W)) u_seg (
        .temp   (temp_code),
        .bp_low (bp_low),
        .bp_ref (bp_ref),
        .bp_h1  (bp_h1),
        .bp_h2  (bp_h2),
        .base   (base),
        .sp_low (sp_low),
        .sp_h1  (sp_h1),
        .sp_h2  (sp_h2),
        .seg    (seg),
        .start  (seg_start),
        .delta  (seg_delta),
        .num    (seg_num),
        .den    (seg_den)
    );

    // Numerator of the interpolation: rise times distance into the segment.
    always_comb begin
        product = PROD_W'(seg_delta) * PROD_W'(seg_num);
    end

    assign accept = sample_valid && !div_busy;

    tcsi_divider #(.NUM_W(PROD_W), .DEN_W(TEMP_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .dividend (product),
        .divisor  (seg_den),
        .busy     (div_busy),
        .last     (div_last),
        .quo_next (quo_next)
    );

    // Hold the segment start for the conversion in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q   <= SEG_CLAMP_LO;
            start_q <= '0;
        end else if (accept) begin
            seg_q   <= seg;
            start_q <= seg_start;
        end
    end

    // Publish the result and pulse done on the final divider step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setpoint_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= div_last;
            if (div_last) begin
                setpoint_q <= start_q + CODE_W'(quo_next);
            end
        end
    end

    assign setpoint = setpoint_q;
    assign done     = done_q;
endmodule

// File: rtl/tc_setpoint_interp_chk.sv
// Assertion checker for tc_setpoint_interp, attached with bind below.
// Observes ports plus the divider busy flag and the captured segment state.
module tc_setpoint_interp_chk #(
    parameter int CODE_W = tcsi_pkg::TCSI_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic              busy,
    input tcsi_pkg::seg_e    seg_q,
    input logic [CODE_W-1:0] start_q,
    input logic [CODE_W-1:0] setpoint,
    input logic              done
);
    import tcsi_pkg::*;

    // R1: reset clears the outputs.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (setpoint == '0 && !done));

    // R6: done lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: output holds between results.
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(setpoint));

    // R7: an idle strobe starts a conversion.
    assert_accept_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !busy) |=> busy);

    // R7: the divider is idle when a result is published.
    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: clamped segments return their start setpoint unchanged.
    assert_clamp_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (seg_q == SEG_CLAMP_LO || seg_q == SEG_CLAMP_HI)) |-> setpoint == start_q);

    // R5: interpolation never falls below the segment start.
    assert_no_undershoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> setpoint >= start_q);
endmodule

bind tc_setpoint_interp tc_setpoint_interp_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .busy         (div_busy),
    .seg_q        (seg_q),
    .start_q      (start_q),
    .setpoint     (setpoint),
    .done         (done)
);

// File: tb/tc_setpoint_interp_bench.sv
// Scoreboard bench: driver tasks push expected setpoints, a monitor pops and
// compares them on every done pulse.
module tc_setpoint_interp_bench;
    localparam int LAT = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] temp_code = '0;
    logic [7:0] base_hi = '0;
    logic       base_lsb = 1'b0;
    logic [4:0] off_low = '0, off_h1 = '0, off_h2 = '0;
    logic [7:0] bp_low = '0, bp_ref = '0, bp_h1 = '0, bp_h2 = '0;
    logic [8:0] setpoint;
    logic       done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    val;
        string req;
    } item_t;
    item_t exp_q[$];

    // Model configuration mirrors what is driven.
    int c_hi, c_lsb, c_ol, c_o1, c_o2, c_bl, c_br, c_b1, c_b2;

    always #5 clk = ~clk;

    tc_setpoint_interp u_tc_setpoint_interp (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .temp_code(temp_code),
        .base_hi(base_hi), .base_lsb(base_lsb), .off_low(off_low), .off_h1(off_h1),
        .off_h2(off_h2), .bp_low(bp_low), .bp_ref(bp_ref), .bp_h1(bp_h1), .bp_h2(bp_h2),
        .setpoint(setpoint), .done(done)
    );

    function automatic int model(int t);
        int b, lo, h1, h2;
        b  = c_hi * 2 + c_lsb;
        lo = b - c_ol;  if (lo < 0) lo = 0;
        h1 = b + c_o1;  if (h1 > 511) h1 = 511;
        h2 = h1 + c_o2; if (h2 > 511) h2 = 511;
        if (t <= c_bl) return lo;
        if (t < c_br)  return lo + ((b - lo) * (t - c_bl)) / (c_br - c_bl);
        if (t < c_b1)  return b + ((h1 - b) * (t - c_br)) / (c_b1 - c_br);
        if (t < c_b2)  return h1 + ((h2 - h1) * (t - c_b1)) / (c_b2 - c_b1);
        return h2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int hi, lsb, ol, o1, o2, bl, br, b1, b2);
        c_hi = hi; c_lsb = lsb; c_ol = ol; c_o1 = o1; c_o2 = o2;
        c_bl = bl; c_br = br; c_b1 = b1; c_b2 = b2;
        base_hi = 8'(hi); base_lsb = 1'(lsb);
        off_low = 5'(ol); off_h1 = 5'(o1); off_h2 = 5'(o2);
        bp_low = 8'(bl); bp_ref = 8'(br); bp_h1 = 8'(b1); bp_h2 = 8'(b2);
    endtask

    // Driver: one strobe, expected result queued, then wait out the conversion.
    task automatic convert(input int t, input string req);
        @(negedge clk);
        temp_code = 8'(t);
        sample_valid = 1'b1;
        exp_q.push_back('{model(t), req});
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    // Monitor: compare every done pulse; flag any change without done.
    int last_sp = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", int'(setpoint), -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(int'(setpoint) == it.val, it.req, int'(setpoint), it.val);
                end
            end else if (int'(setpoint) != last_sp) begin
                check(1'b0, "R6 setpoint moved without done", int'(setpoint), last_sp);
            end
            last_sp = int'(setpoint);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_cfg(8'h6D, 0, 5'h0D, 5'h03, 5'h0A, 8'h02, 8'h1F, 8'h66, 8'hCD);
        repeat (3) @(negedge clk);
        check(setpoint == 9'd0 && done == 1'b0, "R1 reset state", int'(setpoint), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(setpoint == 9'd0 && done == 1'b0, "R1 after reset", int'(setpoint), 0);

        // R3: exact breakpoints
        convert(8'h02, "R3 at low breakpoint");
        convert(8'h1F, "R3 at reference breakpoint");
        convert(8'h66, "R3 at H1 breakpoint");
        convert(8'hCD, "R3 at H2 breakpoint");
        // R4: clamps
        convert(0, "R4 below low clamp");
        convert(255, "R4 above H2 clamp");
        // R5: interior of each segment
        convert(8'h10, "R5 low-ref segment");
        convert(8'h1E, "R5 low-ref just below ref");
        convert(8'h40, "R5 ref-H1 segment");
        convert(8'h80, "R5 H1-H2 segment");
        convert(8'hCC, "R5 H1-H2 just below H2");

        // R2: base LSB and saturation at both ends
        set_cfg(8'h03, 1, 5'h1F, 5'h05, 5'h04, 8'h10, 8'h20, 8'h30, 8'h40);
        convert(8'h10, "R2 low setpoint floors at zero");
        convert(8'h20, "R2 base uses lsb field");
        convert(8'h18, "R5 rise from floored low");
        set_cfg(8'hFE, 1, 5'h02, 5'h1F, 5'h1F, 8'h10, 8'h20, 8'h30, 8'h40);
        convert(8'h30, "R2 H1 ceiling at full scale");
        convert(8'h50, "R2 H2 ceiling at full scale");
        convert(8'h1F, "R5 low-ref near full scale");

        // R6: latency from accepted strobe to done
        set_cfg(8'h6D, 0, 5'h0D, 5'h03, 5'h0A, 8'h02, 8'h1F, 8'h66, 8'hCD);
        begin
            int n;
            @(negedge clk);
            temp_code = 8'h50;
            sample_valid = 1'b1;
            exp_q.push_back('{model(8'h50), "R6 latency result"});
            @(negedge clk);
            sample_valid = 1'b0;
            n = 0;
            while (!done && n < 40) begin
                @(negedge clk);
                n++;
            end
            check(n == LAT, "R6 done latency", n, LAT);
            repeat (3) @(negedge clk);
        end

        // R7 and R8: strobe mid-conversion ignored; config changes ignored
        @(negedge clk);
        temp_code = 8'h30;
        sample_valid = 1'b1;
        exp_q.push_back('{model(8'h30), "R8 result uses captured inputs"});
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (4) @(negedge clk);
        temp_code = 8'hA0;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        base_hi = 8'h20; off_h1 = 5'h1F; bp_ref = 8'h05; temp_code = 8'hF0;
        repeat (LAT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R7 strobe while busy dropped", exp_q.size(), 0);
        set_cfg(8'h6D, 0, 5'h0D, 5'h03, 5'h0A, 8'h02, 8'h1F, 8'h66, 8'hCD);

        // R7: strobe in the completion cycle dropped; strobe in done cycle accepted
        @(negedge clk);
        temp_code = 8'h08;
        sample_valid = 1'b1;
        exp_q.push_back('{model(8'h08), "R7 first conversion"});
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        temp_code = 8'hB0;
        sample_valid = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R7 done in completion cycle", int'(done), 1);
        temp_code = 8'h70;
        exp_q.push_back('{model(8'h70), "R7 strobe in done cycle accepted"});
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (LAT + 6) @(negedge clk);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule